// File: doc/BRIEF.md
# Dual-Convention Host Register Port

This block connects a small set of configuration and interrupt registers to an 8-bit microprocessor bus. Two static mode pins choose how the host drives the bus. The first pin picks between a shared data strobe with a read/write select line, and separate active-low read and write strobes. The second pin picks between one bidirectional bus that carries the address and then the data, and a dedicated address input with the bidirectional bus used only for data.

All bus inputs are asynchronous to the internal clock. They pass through a two-stage synchronizer, and strobe and latch edges are found on the synchronized copies. The host must therefore hold each strobe phase for at least three internal clock periods.

The address is latched when ALE falls. Write data is taken when the write strobe ends. During a read, the port drives the addressed register onto the bus through a separate output-data / output-enable pair. The wait (ready) and interrupt outputs are open-drain enables: 1 means the pin is pulled low. An asynchronous active-low reset loads defined values into every register.

Top module: `hostbus_port`

## Requirements
- R1: When mode_ds = 1, strb_n is an active-low data strobe and rw_wr is a read/write select (1 = read). A write happens on the rising edge of strb_n while rw_wr = 0.
- R2: When mode_ds = 0, strb_n is an active-low read strobe and rw_wr is an active-low write strobe. A write happens on the rising edge of rw_wr. Pulsing strb_n never writes.
- R3: On the falling edge of ALE, the address is taken from ad_in when mode_mux = 1 and from addr_in when mode_mux = 0. The other source is ignored.
- R4: While cs_n = 1, no register is written and data_oe stays 0.
- R5: During a read with cs_n = 0, data_oe is 1 and data_out holds the addressed register. This is true from the second internal clock after the read strobe is synchronized until the strobe ends.
- R6: ready_oe is 1 from the start of a read strobe with cs_n = 0 until two internal clocks after that read is seen in the internal domain. It is 0 at all other times, including during writes.
- R7: Reset (rst_n = 0, asynchronous) loads these values: 0x00 = 0x01 (bit 0 is the power-down bit), 0x01 = 0x00 (clock-rate bits [1:0] cleared), 0x22 = 0x00 (clock-rate bits [1:0] cleared), interrupt flags at 0x10 = 0x00, and interrupt mask at 0x11 = 0xFF. The registers at 0x00, 0x01, 0x22 and 0x11 are read/write over all 8 bits.
- R8: A 1-cycle pulse on irq_evt[i] sets flag bit i at 0x10. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle resolve to set.
- R9: irq_oe is 1 exactly when some flag bit is 1 and its mask bit at 0x11 is 0.
- R10: Reads of any address other than 0x00, 0x01, 0x10, 0x11 and 0x22 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ds | input | 1 | 1: data strobe + read/write select; 0: separate read/write strobes |
| mode_mux | input | 1 | 1: address on ad_in; 0: address on addr_in |
| ale | input | 1 | Address latch enable, address taken on its falling edge |
| cs_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Data strobe or read strobe, active low |
| rw_wr | input | 1 | Read/write select or active-low write strobe |
| ad_in | input | 8 | Input side of the bidirectional address/data bus |
| addr_in | input | 8 | Dedicated address bus |
| irq_evt | input | 8 | Interrupt event pulses, one per flag bit |
| data_out | output | 8 | Read data for the bus driver |
| data_oe | output | 1 | Bus driver enable |
| ready_oe | output | 1 | 1 pulls the open-drain ready line low (wait) |
| irq_oe | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The same register writes and read-backs are run under all four combinations of the two mode pins. During the address phase, the unselected address source carries a conflicting value. This shows which source the latch really uses, and whether the correct strobe edge performs the write. A read in separate-strobe mode with other data on the bus shows that the read strobe never writes. Transfers with chip select high, and to unmapped addresses, show that no state changes. The interrupt sequence contrasts a masked flag, an unmasked flag, a write of 0 and a write of 1 to the flag. A mid-run reset shows the defined values come back.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_CFG_PWR = 8'h00;
    localparam logic [AW-1:0] A_CFG_MON = 8'h01;
    localparam logic [AW-1:0] A_IRQ_FLG = 8'h10;
    localparam logic [AW-1:0] A_IRQ_MSK = 8'h11;
    localparam logic [AW-1:0] A_CFG_CLK = 8'h22;

    localparam logic [DW-1:0] RV_CFG_PWR = 8'h01;
    localparam logic [DW-1:0] RV_CFG_MON = 8'h00;
    localparam logic [DW-1:0] RV_CFG_CLK = 8'h00;
    localparam logic [DW-1:0] RV_IRQ_FLG = 8'h00;
    localparam logic [DW-1:0] RV_IRQ_MSK = 8'hFF;

    typedef struct packed {
        logic [DW-1:0] pwr;
        logic [DW-1:0] mon;
        logic [DW-1:0] clk;
        logic [DW-1:0] flg;
        logic [DW-1:0] msk;
    } regs_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] stg_d;
            if (s == 0) begin : g_first
                always_comb stg_d = d;
            end else begin : g_next
                always_comb stg_d = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST;
                else        stg_q[s] <= stg_d;
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int RD_WAIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ds,
    input  logic          mode_mux,
    input  logic          ale_s,
    input  logic          cs_s,
    input  logic          strb_s,
    input  logic          rw_s,
    input  logic [DW-1:0] ad_s,
    input  logic [AW-1:0] addr_s,
    output logic [AW-1:0] addr_q_o,
    output logic          wr_pulse,
    output logic [DW-1:0] wr_data,
    output logic          rd_act,
    output logic          rd_first,
    output logic          rd_ready
);
    localparam int CW = $clog2(RD_WAIT + 1);

    typedef struct packed {
        logic          ale_p;
        logic          strb_p;
        logic          rw_p;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  ale_fall;

    always_comb begin
        st_d     = st_q;
        ale_fall = st_q.ale_p && !ale_s;
        rd_act   = !cs_s && !strb_s && (mode_ds ? rw_s : 1'b1);
        if (mode_ds)
            wr_pulse = !cs_s && !st_q.strb_p && strb_s && !rw_s;
        else
            wr_pulse = !cs_s && !st_q.rw_p && rw_s;
        wr_data  = ad_s;
        rd_first = rd_act && (st_q.cnt == '0);
        rd_ready = rd_act && (st_q.cnt == CW'(RD_WAIT));

        st_d.ale_p  = ale_s;
        st_d.strb_p = strb_s;
        st_d.rw_p   = rw_s;
        if (ale_fall)
            st_d.addr = mode_mux ? ad_s : addr_s;
        if (!rd_act)
            st_d.cnt = '0;
        else if (st_q.cnt != CW'(RD_WAIT))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ale_p  <= 1'b0;
            st_q.strb_p <= 1'b1;
            st_q.rw_p   <= 1'b1;
            st_q.addr   <= '0;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q_o = st_q.addr;

    // R1 / R2: an edge yields exactly one write pulse
    p_wr_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
    // R3: latched address only moves on an ALE fall
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_fall |=> $stable(st_q.addr));
    // R6: ready release only after a read was already active
    p_ready_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(rd_act));
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
    import hb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] irq_evt,
    output logic [DW-1:0] rd_data,
    output logic          irq_any
);
    regs_t rg_q, rg_d;
    logic [DW-1:0] clr;

    always_comb begin
        rg_d = rg_q;
        clr  = '0;
        if (wr_en) begin
            case (addr)
                A_CFG_PWR: rg_d.pwr = wr_data;
                A_CFG_MON: rg_d.mon = wr_data;
                A_CFG_CLK: rg_d.clk = wr_data;
                A_IRQ_MSK: rg_d.msk = wr_data;
                A_IRQ_FLG: clr      = wr_data;
                default:   ;
            endcase
        end
        rg_d.flg = (rg_q.flg & ~clr) | irq_evt;

        case (addr)
            A_CFG_PWR: rd_data = rg_q.pwr;
            A_CFG_MON: rd_data = rg_q.mon;
            A_CFG_CLK: rd_data = rg_q.clk;
            A_IRQ_MSK: rd_data = rg_q.msk;
            A_IRQ_FLG: rd_data = rg_q.flg;
            default:   rd_data = '0;
        endcase
        irq_any = |(rg_q.flg & ~rg_q.msk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.pwr <= RV_CFG_PWR;
            rg_q.mon <= RV_CFG_MON;
            rg_q.clk <= RV_CFG_CLK;
            rg_q.flg <= RV_IRQ_FLG;
            rg_q.msk <= RV_IRQ_MSK;
        end else begin
            rg_q <= rg_d;
        end
    end

    // R8: an event pulse always leaves its flag set
    p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt != '0) |=> ((rg_q.flg & $past(irq_evt)) == $past(irq_evt)));
    // R8: flags hold without events or writes
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && irq_evt == '0) |=> $stable(rg_q.flg));
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RD_WAIT     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ds,
    input  logic          mode_mux,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          strb_n,
    input  logic          rw_wr,
    input  logic [DW-1:0] ad_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] irq_evt,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          ready_oe,
    output logic          irq_oe
);
    localparam int CTLW = 4;
    localparam int BUSW = DW + AW;

    logic [CTLW-1:0] ctl_s;
    logic [BUSW-1:0] bus_s;
    logic [AW-1:0]   addr_q;
    logic            wr_pulse, rd_act, rd_first, rd_ready, irq_any;
    logic [DW-1:0]   wr_data, rd_data;
    logic            raw_rd;

    hb_sync #(.W(CTLW), .STAGES(SYNC_STAGES), .RST(4'b0111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({ale, cs_n, strb_n, rw_wr}), .q(ctl_s));

    hb_sync #(.W(BUSW), .STAGES(SYNC_STAGES), .RST('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .d({ad_in, addr_in}), .q(bus_s));

    hb_ctrl #(.RD_WAIT(RD_WAIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mode_ds(mode_ds), .mode_mux(mode_mux),
        .ale_s(ctl_s[3]), .cs_s(ctl_s[2]), .strb_s(ctl_s[1]), .rw_s(ctl_s[0]),
        .ad_s(bus_s[BUSW-1:AW]), .addr_s(bus_s[AW-1:0]),
        .addr_q_o(addr_q), .wr_pulse(wr_pulse), .wr_data(wr_data),
        .rd_act(rd_act), .rd_first(rd_first), .rd_ready(rd_ready));

    hb_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr_q),
        .wr_en(wr_pulse), .wr_data(wr_data), .irq_evt(irq_evt),
        .rd_data(rd_data), .irq_any(irq_any));

    typedef struct packed {
        logic          drive;
        logic [DW-1:0] dout;
    } out_t;

    out_t out_q, out_d;

    always_comb begin
        out_d       = out_q;
        out_d.drive = rd_act;
        if (rd_first)
            out_d.dout = rd_data;
        raw_rd = !cs_n && !strb_n && (mode_ds ? rw_wr : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign data_out = out_q.dout;
    assign data_oe  = out_q.drive && !cs_n;
    assign ready_oe = raw_rd && !rd_ready;
    assign irq_oe   = irq_any;

    // R5: the bus is driven only after a synchronized read was seen
    p_oe_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(rd_act));
    // R4: a write pulse never coincides with driving the bus
    p_no_wr_while_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !rd_act);
endmodule

// File: tb/tb_hostbus_port.sv
module tb_hostbus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ds = 1'b1, mode_mux = 1'b1;
    logic       ale = 1'b0, cs_n = 1'b1, strb_n = 1'b1, rw_wr = 1'b1;
    logic [7:0] ad_in = '0, addr_in = '0, irq_evt = '0;
    logic [7:0] data_out;
    logic       data_oe, ready_oe, irq_oe;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] smp_val;
    event       smp_ev;

    always #10 clk = ~clk;

    hostbus_port dut (
        .clk(clk), .rst_n(rst_n), .mode_ds(mode_ds), .mode_mux(mode_mux),
        .ale(ale), .cs_n(cs_n), .strb_n(strb_n), .rw_wr(rw_wr),
        .ad_in(ad_in), .addr_in(addr_in), .irq_evt(irq_evt),
        .data_out(data_out), .data_oe(data_oe), .ready_oe(ready_oe), .irq_oe(irq_oe));

    task automatic check(input string tg, input logic [7:0] act, input logic [7:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tg, act, expv);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(smp_ev);
            check(tag_q.pop_front(), smp_val, exp_q.pop_front());
        end
    end

    task automatic addr_phase(input logic csn, input logic [7:0] a);
        @(negedge clk);
        cs_n = csn;
        if (mode_mux) begin ad_in = a; addr_in = ~a; end
        else begin addr_in = a; ad_in = ~a; end
        ale = 1'b1;
        clks(3);
        ale = 1'b0;
        clks(3);
    endtask

    task automatic bus_wr(input logic csn, input logic [7:0] a, input logic [7:0] d);
        addr_phase(csn, a);
        ad_in = d;
        if (mode_ds) begin
            rw_wr = 1'b0; strb_n = 1'b0;
            clks(4);
            check("R6 no wait on write", {7'd0, ready_oe}, 8'd0);
            strb_n = 1'b1;
            clks(4);
            rw_wr = 1'b1;
        end else begin
            rw_wr = 1'b0;
            clks(4);
            check("R6 no wait on write", {7'd0, ready_oe}, 8'd0);
            rw_wr = 1'b1;
            clks(4);
        end
        cs_n = 1'b1;
        clks(3);
    endtask

    task automatic bus_rd(input logic csn, input logic [7:0] a, input logic [7:0] expv, input string tg);
        addr_phase(csn, a);
        ad_in = 8'hC3;
        rw_wr = 1'b1;
        strb_n = 1'b0;
        #1;
        check("R6 wait at strobe start", {7'd0, ready_oe}, {7'd0, !csn});
        clks(8);
        check("R6 wait released", {7'd0, ready_oe}, 8'd0);
        if (!csn) begin
            check("R5 bus driven", {7'd0, data_oe}, 8'd1);
            exp_q.push_back(expv);
            tag_q.push_back(tg);
            smp_val = data_out;
            ->smp_ev;
            #1;
        end else begin
            check("R4 bus quiet with cs high", {7'd0, data_oe}, 8'd0);
        end
        strb_n = 1'b1;
        clks(3);
        cs_n = 1'b1;
        clks(3);
        check("R5 bus released", {7'd0, data_oe}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clks(3);
        check("R7 reset oe", {6'd0, data_oe, irq_oe}, 8'd0);
        check("R7 reset ready", {7'd0, ready_oe}, 8'd0);
        rst_n = 1'b1;
        clks(2);

        // data strobe, multiplexed
        mode_ds = 1'b1; mode_mux = 1'b1;
        bus_rd(1'b0, 8'h00, 8'h01, "R7 pwr reset");
        bus_rd(1'b0, 8'h01, 8'h00, "R7 mon reset");
        bus_rd(1'b0, 8'h22, 8'h00, "R7 clk reset");
        bus_rd(1'b0, 8'h11, 8'hFF, "R7 mask reset");
        bus_rd(1'b0, 8'h10, 8'h00, "R7 flags reset");
        bus_wr(1'b0, 8'h22, 8'hA5);
        bus_rd(1'b0, 8'h22, 8'hA5, "R1 ds write");

        // separate strobes, multiplexed
        mode_ds = 1'b0;
        bus_wr(1'b0, 8'h01, 8'h3C);
        bus_rd(1'b0, 8'h01, 8'h3C, "R2 wr strobe write");
        bus_rd(1'b0, 8'h01, 8'h3C, "R2 read strobe no write");

        // separate strobes, separate address
        mode_mux = 1'b0;
        bus_wr(1'b0, 8'h00, 8'h5A);
        bus_rd(1'b0, 8'h00, 8'h5A, "R3 addr_in write");
        bus_rd(1'b0, 8'h22, 8'hA5, "R3 ad_in ignored");

        // data strobe, separate address
        mode_ds = 1'b1;
        bus_wr(1'b0, 8'h11, 8'h7E);
        bus_rd(1'b0, 8'h11, 8'h7E, "R3 R1 mask write");
        bus_wr(1'b0, 8'h11, 8'hFF);

        // chip select high
        bus_wr(1'b1, 8'h22, 8'hFF);
        bus_rd(1'b1, 8'h22, 8'h00, "R4 read cs high");
        bus_rd(1'b0, 8'h22, 8'hA5, "R4 write cs high ignored");

        // unmapped
        bus_wr(1'b0, 8'h40, 8'h77);
        bus_rd(1'b0, 8'h40, 8'h00, "R10 unmapped");
        bus_rd(1'b0, 8'h22, 8'hA5, "R10 write no alias");

        // interrupts
        @(negedge clk); irq_evt = 8'h04;
        @(negedge clk); irq_evt = 8'h00;
        clks(1);
        check("R9 masked flag quiet", {7'd0, irq_oe}, 8'd0);
        bus_rd(1'b0, 8'h10, 8'h04, "R8 evt sets flag");
        bus_wr(1'b0, 8'h11, 8'hFB);
        check("R9 unmasked flag asserts", {7'd0, irq_oe}, 8'd1);
        bus_wr(1'b0, 8'h10, 8'h00);
        bus_rd(1'b0, 8'h10, 8'h04, "R8 write zero keeps");
        bus_wr(1'b0, 8'h10, 8'h04);
        check("R9 cleared flag quiet", {7'd0, irq_oe}, 8'd0);
        bus_rd(1'b0, 8'h10, 8'h00, "R8 write one clears");

        // reset mid-run
        @(negedge clk); rst_n = 1'b0;
        clks(2);
        rst_n = 1'b1;
        clks(2);
        bus_rd(1'b0, 8'h00, 8'h01, "R7 pwr after reset");
        bus_rd(1'b0, 8'h11, 8'hFF, "R7 mask after reset");
        bus_rd(1'b0, 8'h22, 8'h00, "R7 clk after reset");

        clks(4);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule